// File: doc/BRIEF.md
# Rank-Counting Time Sorter

This block takes an unordered frame of time values and returns them in ascending order. Each time enters a chain of cells. The first empty cell it reaches keeps it. While a time walks past occupied cells, it and each cell compare values. The smaller of the two holds its rank. The larger, or the later arrival when the values are equal, adds one to its rank. When a time settles in a cell, it takes the rank it has gathered. The result is that every settled entry holds a unique rank in the range 0 to count-1.

An end-of-frame strobe starts three steps. First the block waits for any time still moving through the chain to settle. Next the cells shift down toward cell 0, and each (time, rank) pair is written into a RAM at the address given by its rank. Finally the RAM is read from address 0 up to the number of entries counted in the frame. This gives a contiguous, sorted output burst, with a last flag on the final entry. Shifting the cells out also leaves every cell empty, so the next frame starts clean. Times that arrive while a frame is being emptied are ignored.

Top module: `rank_sorter`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low.
- R2: Every time accepted in a frame appears exactly once on `out_time`, with `out_valid` high, and the burst is in non-decreasing numeric order.
- R3: Equal times are all emitted. Arrival order gives each of them its own rank, so no copy is lost and no RAM word is left stale.
- R4: The output of a frame is one contiguous burst of `out_valid` cycles. `out_last` is high only on its final entry, and the cycle after `out_last` has `out_valid` low.
- R5: A time is accepted only while the block is collecting. `in_valid` during draining, shifting or readout has no effect on the output.
- R6: At most DEPTH times are accepted per frame. Further times in the same frame are ignored, and the burst holds the first DEPTH times in sorted order.
- R7: An end-of-frame strobe with no accepted time produces no output.
- R8: A time presented in the same cycle as `in_eof` belongs to the frame being closed.
- R9: A frame with fewer entries than the one before it returns only its own times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_time` carries a time this cycle |
| in_time | input | TW | Time value to rank |
| in_eof | input | 1 | Closes the current frame |
| out_valid | output | 1 | `out_time` carries a sorted entry |
| out_time | output | TW | Sorted time, smallest first |
| out_last | output | 1 | Final entry of the frame's burst |

## Verification
The bench targets these corner cases:
- **All-equal frames.** A design that counted ties on both sides would give two entries the same rank. One RAM word would be written twice, and another would keep a value from an earlier frame.
- **Frames longer than the chain.** If the extra times were admitted, they would raise ranks beyond the RAM range or drop entries.
- **Empty frames and single-entry frames.** These expose a readout counter that underflows or a last flag that never rises.
- **Input during readout, and a short frame right after a long one.** These show whether busy-time input leaks in and whether every cell and counter is cleared.

Random frames with gaps between inputs and small value ranges then exercise timing between times still in flight.

// File: rtl/rsort_pkg.sv
package rsort_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT,
    PH_DRAIN,
    PH_SCATTER,
    PH_EMIT
  } phase_e;
endpackage

// File: rtl/rank_cell.sv
// One stage of the ranking chain: holds a settled entry or forwards a visitor.
module rank_cell #(
  parameter int TW = 16,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          in_v,
  input  logic [TW-1:0] in_time,
  input  logic [PW-1:0] in_pos,
  input  logic          nxt_occ,
  input  logic [TW-1:0] nxt_time,
  input  logic [PW-1:0] nxt_pos,
  output logic          occ,
  output logic [TW-1:0] st_time,
  output logic [PW-1:0] st_pos,
  output logic          fw_v,
  output logic [TW-1:0] fw_time,
  output logic [PW-1:0] fw_pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occ     <= 1'b0;
      st_time <= '0;
      st_pos  <= '0;
      fw_v    <= 1'b0;
      fw_time <= '0;
      fw_pos  <= '0;
    end else if (shift_en) begin
      occ     <= nxt_occ;
      st_time <= nxt_time;
      st_pos  <= nxt_pos;
      fw_v    <= 1'b0;
    end else begin
      fw_v <= 1'b0;
      if (in_v) begin
        if (!occ) begin
          occ     <= 1'b1;
          st_time <= in_time;
          st_pos  <= in_pos;
        end else begin
          fw_v    <= 1'b1;
          fw_time <= in_time;
          if (in_time < st_time) begin
            st_pos <= st_pos + 1'b1;
            fw_pos <= in_pos;
          end else begin
            fw_pos <= in_pos + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rank_ram.sv
// Simple dual-port memory with registered read, suitable for block RAM.
module rank_ram #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rank_sorter.sv
module rank_sorter #(
  parameter int DEPTH = 32,
  parameter int TW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [TW-1:0] in_time,
  input  logic          in_eof,
  output logic          out_valid,
  output logic [TW-1:0] out_time,
  output logic          out_last
);
  import rsort_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  phase_e        phase;
  logic [CW-1:0] count;
  logic [PW-1:0] idx;
  logic          accept, scatter, lane_busy, idx_final;

  logic          lane_v [DEPTH+1];
  logic [TW-1:0] lane_t [DEPTH+1];
  logic [PW-1:0] lane_p [DEPTH+1];
  logic          occ    [DEPTH+1];
  logic [TW-1:0] st_t   [DEPTH+1];
  logic [PW-1:0] st_p   [DEPTH+1];

  assign accept    = (phase == PH_COLLECT) && in_valid && (count < CW'(DEPTH));
  assign scatter   = (phase == PH_SCATTER);
  assign idx_final = (CW'(idx) == count - CW'(1));

  assign lane_v[0] = accept;
  assign lane_t[0] = in_time;
  assign lane_p[0] = '0;
  assign occ[DEPTH]  = 1'b0;
  assign st_t[DEPTH] = '0;
  assign st_p[DEPTH] = '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    rank_cell #(.TW(TW), .PW(PW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .shift_en (scatter),
      .in_v     (lane_v[g]),
      .in_time  (lane_t[g]),
      .in_pos   (lane_p[g]),
      .nxt_occ  (occ[g+1]),
      .nxt_time (st_t[g+1]),
      .nxt_pos  (st_p[g+1]),
      .occ      (occ[g]),
      .st_time  (st_t[g]),
      .st_pos   (st_p[g]),
      .fw_v     (lane_v[g+1]),
      .fw_time  (lane_t[g+1]),
      .fw_pos   (lane_p[g+1])
    );
  end

  always_comb begin
    lane_busy = 1'b0;
    for (int k = 1; k <= DEPTH; k++) lane_busy = lane_busy | lane_v[k];
  end

  rank_ram #(.AW(PW), .DW(TW)) u_ram (
    .clk   (clk),
    .we    (scatter),
    .waddr (st_p[0]),
    .wdata (st_t[0]),
    .re    (phase == PH_EMIT),
    .raddr (idx),
    .rdata (out_time)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_COLLECT;
      count     <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (phase)
        PH_COLLECT: begin
          if (accept) count <= count + 1'b1;
          if (in_eof) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (!lane_busy) begin
            idx   <= '0;
            phase <= (count == '0) ? PH_COLLECT : PH_SCATTER;
          end
        end
        PH_SCATTER: begin
          idx <= idx + 1'b1;
          if (idx_final) begin
            idx   <= '0;
            phase <= PH_EMIT;
          end
        end
        default: begin
          out_valid <= 1'b1;
          idx       <= idx + 1'b1;
          if (idx_final) begin
            out_last <= 1'b1;
            idx      <= '0;
            count    <= '0;
            phase    <= PH_COLLECT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rank_sorter_chk.sv
module rank_sorter_chk #(
  parameter int DEPTH = 32,
  parameter int TW    = 16,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_last,
  input logic [TW-1:0] out_time,
  input logic [CW-1:0] count,
  input logic          scatter,
  input logic          head_occ,
  input logic          tail_v
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!out_valid && !out_last));

  a_r4_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r4_burst_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  a_r4_gap_after_last: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_valid);

  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_time >= $past(out_time)));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r6_no_spill: assert property (@(posedge clk) disable iff (rst)
    !tail_v);

  a_r2_head_full_on_scatter: assert property (@(posedge clk) disable iff (rst)
    scatter |-> head_occ);
endmodule

bind rank_sorter rank_sorter_chk #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_time  (out_time),
  .count     (count),
  .scatter   (scatter),
  .head_occ  (occ[0]),
  .tail_v    (lane_v[DEPTH])
);

// File: tb/tb_rank_sorter.sv
module tb_rank_sorter;
  localparam int DEPTH = 32;
  localparam int TW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_time = '0;
  logic          in_eof = 1'b0;
  logic          out_valid, out_last;
  logic [TW-1:0] out_time;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int unsigned vals [80];
  int unsigned expv [80];

  always #5 clk = ~clk;

  rank_sorter #(.DEPTH(DEPTH), .TW(TW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_time(in_time),
    .in_eof(in_eof), .out_valid(out_valid), .out_time(out_time), .out_last(out_last)
  );

  task automatic ck(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected burst: first DEPTH accepted times, ascending.
  function automatic int build_expected(input int n);
    int m = (n > DEPTH) ? DEPTH : n;
    for (int i = 0; i < m; i++) expv[i] = vals[i];
    for (int i = 1; i < m; i++) begin
      int unsigned key = expv[i];
      int j = i - 1;
      while (j >= 0 && expv[j] > key) begin
        expv[j+1] = expv[j];
        j--;
      end
      expv[j+1] = key;
    end
    return m;
  endfunction

  task automatic run_frame(input int n, input bit gaps, input bit noise, input string tag);
    int m = build_expected(n);
    int got = 0;
    if (n == 0) begin
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b1;
    end
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int idle = $urandom_range(0, 2);
        for (int k = 0; k < idle; k++) begin
          @(negedge clk);
          in_valid = 1'b0; in_eof = 1'b0;
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_time  = TW'(vals[i]);
      in_eof   = (i == n - 1);
    end
    for (int cyc = 0; cyc < 4 * DEPTH + 40; cyc++) begin
      @(negedge clk);
      in_eof = 1'b0;
      if (out_valid) begin
        if (got < m) begin
          ck(out_time == TW'(expv[got]), {tag, " value"}, out_time, expv[got]);
          ck(out_last == (got == m - 1), "R4 last flag position", out_last, (got == m - 1));
        end
        got++;
      end
      if (noise && !out_last) begin
        in_valid = 1'b1;
        in_time  = TW'($urandom);
      end else begin
        in_valid = 1'b0;
      end
      if (out_last) break;
    end
    in_valid = 1'b0;
    ck(got == m, {tag, " entry count"}, got, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    ck(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    ck(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    ck(out_last == 1'b0, "R1 out_last after reset", out_last, 0);

    for (int i = 0; i < 8; i++) vals[i] = 800 - 100 * i;
    run_frame(8, 0, 0, "R2 descending");

    for (int i = 0; i < 6; i++) vals[i] = 77;
    run_frame(6, 0, 0, "R3 all equal");

    vals[0] = 4; vals[1] = 9; vals[2] = 4; vals[3] = 1; vals[4] = 9; vals[5] = 4;
    run_frame(6, 1, 0, "R3 mixed ties");

    vals[0] = 12345;
    run_frame(1, 0, 0, "R8 single time on eof cycle");

    run_frame(0, 0, 0, "R7 empty frame");

    for (int i = 0; i < 36; i++) vals[i] = (i * 37) % 101;
    run_frame(36, 0, 0, "R6 overflow");

    for (int i = 0; i < 10; i++) vals[i] = 500 + ((i * 7) % 10);
    run_frame(10, 0, 1, "R5 busy input ignored");

    vals[0] = 3; vals[1] = 2; vals[2] = 1;
    run_frame(3, 0, 0, "R9 short after long");

    vals[0] = 16'hFFFF; vals[1] = 0; vals[2] = 16'hFFFF; vals[3] = 0; vals[4] = 16'h8000;
    run_frame(5, 0, 0, "R2 extremes");

    for (int f = 0; f < 40; f++) begin
      int n = $urandom_range(1, DEPTH);
      bit narrow = $urandom_range(0, 1);
      for (int i = 0; i < n; i++) vals[i] = narrow ? $urandom_range(0, 7) : ($urandom & 16'hFFFF);
      run_frame(n, f[0], f[2], "R2 random frame");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule